// File: doc/BRIEF.md
# Instruction Fetch Tag Tracker

This block sits between a warp scheduler's fetch queue and an instruction cache. Each fetch request carries a program counter and a warp id. The block gives each request a tag from a small table of free slots and stores the request's context in that slot. It then sends a read to the cache with the program counter as the address. Cache responses may come back in any order. Each response's tag selects its stored context, which goes out on a decode-bound stream, and the tag is freed.

In each cycle the block accepts at most one response and sends at most one request. The response is always handled first, so a tag freed by a response can be handed to a new request in the same cycle. Two counters are kept. The first is the number of fetches in flight. The second is a running latency total, which adds the in-flight count of every cycle.

Top module: `ifetch_tag_tracker`

## Requirements
- R1: After reset no tag is in use, `outstanding` and `lat_total` read 0, and the first request accepted gets tag 0.
- R2: When `req_valid` is high and a tag is free, the same cycle shows `req_ready`=1 and `icreq_valid`=1, with `icreq_addr`=`req_pc`, `icreq_read`=1 and `icreq_tag` equal to the lowest-numbered free tag.
- R3: When no tag is free after response handling, `req_ready` and `icreq_valid` are 0, and the request stays waiting at its input.
- R4: A response whose tag is in use, with `dec_ready` high, shows `dec_valid`=1 and `rsp_ready`=1 in that cycle. `dec_pc` and `dec_warp` show the context stored for that tag, and the tag becomes free at the clock edge.
- R5: A response whose tag is in use, while `dec_ready` is low, sees `rsp_ready`=0. Its tag stays in use and the counters do not count it.
- R6: A tag freed by a response is free for a request in the same cycle. When it is the only free tag, `icreq_tag` equals it.
- R7: A response whose tag is not in use is dropped. It sees `rsp_ready`=1 and `dec_valid`=0, and it changes neither the tags nor `outstanding`.
- R8: `outstanding` rises by 1 for each request sent and falls by 1 for each response consumed. It is unchanged when both happen in one cycle, and it never exceeds the number of tags.
- R9: On each clock edge out of reset, `lat_total` increases by the value `outstanding` had in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A fetch request waits at the head of the queue |
| req_ready | output | 1 | A tag is free; the waiting request is taken this cycle |
| req_pc | input | PC_W | Program counter of the waiting request |
| req_warp | input | WID_W | Warp id of the waiting request |
| icreq_valid | output | 1 | Cache read request sent this cycle |
| icreq_read | output | 1 | Read flag of the cache request (1 = read) |
| icreq_addr | output | PC_W | Cache request address |
| icreq_tag | output | TAG_W | Tag carried by the cache request |
| rsp_valid | input | 1 | Cache response present |
| rsp_ready | output | 1 | Cache response taken this cycle |
| rsp_tag | input | TAG_W | Tag of the cache response |
| dec_valid | output | 1 | Context going out to decode |
| dec_ready | input | 1 | Decode can take a context |
| dec_pc | output | PC_W | Program counter of the returned fetch |
| dec_warp | output | WID_W | Warp id of the returned fetch |
| outstanding | output | CNT_W | Number of fetches in flight |
| lat_total | output | LAT_W | Running sum of in-flight counts over cycles |

## Verification
The assertions check the counter rules on every cycle. The in-flight count must move by exactly the sent-minus-consumed amount, and it must stay within the table size. The latency total must step by the previous in-flight count. A held response must not be taken, and a stale response must never block. Other behaviours can only be seen in the bench's scenarios: which tag is chosen, that the context returned under a tag matches what was stored, and that a tag freed and reused in the same cycle works. The bench covers these with a directed fill, stall, hold and reuse sequence. It follows this with a long pseudo-random sweep over all four tags, scored against an arithmetic model.

// File: rtl/ift_pkg.sv
// Package ift_pkg
// Shared helpers for the fetch tag tracker.
// Assumes: parameters are positive integers.
package ift_pkg;

    // Width of an index into n entries; at least one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a count that can reach n inclusive.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ift_free_pick.sv
// Module ift_free_pick
// Finds the lowest-numbered free slot in a busy vector.
// Assumes: NUM_SLOTS >= 2; the result is combinational.
module ift_free_pick #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned TAG_W     = 2
) (
    input  logic [NUM_SLOTS-1:0] busy,
    output logic                 any_free,
    output logic [TAG_W-1:0]     pick
);

    // Priority scan from the top so the lowest free index wins.
    always_comb begin
        any_free = 1'b0;
        pick     = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                pick     = TAG_W'(i);
            end
        end
    end

endmodule

// File: rtl/ift_tag_table.sv
// Module ift_tag_table
// Holds one context slot per tag: a busy flag, a program counter and a warp id.
// Assumes: at most one allocate and one free per cycle; when both name the
// same slot, allocate wins (the slot was freed and reused in one cycle).
module ift_tag_table #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned TAG_W     = 2,
    parameter int unsigned PC_W      = 32,
    parameter int unsigned WID_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic [TAG_W-1:0]     alloc_tag,
    input  logic [PC_W-1:0]      alloc_pc,
    input  logic [WID_W-1:0]     alloc_warp,
    input  logic                 free_en,
    input  logic [TAG_W-1:0]     free_tag,
    input  logic [TAG_W-1:0]     rd_tag,
    output logic [NUM_SLOTS-1:0] busy,
    output logic [PC_W-1:0]      rd_pc,
    output logic [WID_W-1:0]     rd_warp
);

    logic [PC_W-1:0]  pc_q   [NUM_SLOTS];
    logic [WID_W-1:0] warp_q [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic hit_alloc;
        logic hit_free;

        // Decode the allocate and free strobes for this slot.
        always_comb begin
            hit_alloc = alloc_en && (alloc_tag == TAG_W'(s));
            hit_free  = free_en && (free_tag == TAG_W'(s));
        end

        // Busy flag: cleared by reset or free, set by allocate (allocate wins).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[s] <= 1'b0;
            end else if (hit_alloc) begin
                busy[s] <= 1'b1;
            end else if (hit_free) begin
                busy[s] <= 1'b0;
            end
        end

        // Context storage: captured on allocate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[s]   <= '0;
                warp_q[s] <= '0;
            end else if (hit_alloc) begin
                pc_q[s]   <= alloc_pc;
                warp_q[s] <= alloc_warp;
            end
        end
    end

    // Read port for the response lookup.
    always_comb begin
        rd_pc   = pc_q[rd_tag];
        rd_warp = warp_q[rd_tag];
    end

endmodule

// File: rtl/ift_counters.sv
// Module ift_counters
// In-flight fetch count and running latency total.
// Assumes: inc/dec are single-cycle strobes; the count never underflows;
// the latency total wraps at LAT_W bits.
module ift_counters #(
    parameter int unsigned CNT_W = 3,
    parameter int unsigned LAT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] outstanding,
    output logic [LAT_W-1:0] lat_total
);

    // In-flight count: +1 per request, -1 per consumed response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   outstanding <= outstanding + CNT_W'(1);
                2'b01:   outstanding <= outstanding - CNT_W'(1);
                default: outstanding <= outstanding;
            endcase
        end
    end

    // Latency total: adds this cycle's count before it is updated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_total <= '0;
        end else begin
            lat_total <= lat_total + LAT_W'(outstanding);
        end
    end

endmodule

// File: rtl/ifetch_tag_tracker.sv
// Module ifetch_tag_tracker
// Issues tagged instruction-cache reads for queued fetches and returns the
// stored context of each response to decode, in response order. Each cycle
// the response is handled before the request, so a freed tag can be reused
// at once.
// Assumes: the cache takes every request; NUM_WARPS is a power of two >= 2
// so every rsp_tag value names a slot.
module ifetch_tag_tracker
    import ift_pkg::*;
#(
    parameter int unsigned NUM_WARPS = 4,
    parameter int unsigned PC_W      = 32,
    parameter int unsigned LAT_W     = 32,
    localparam int unsigned TAG_W    = idx_bits(NUM_WARPS),
    localparam int unsigned WID_W    = idx_bits(NUM_WARPS),
    localparam int unsigned CNT_W    = cnt_bits(NUM_WARPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PC_W-1:0]  req_pc,
    input  logic [WID_W-1:0] req_warp,
    output logic             icreq_valid,
    output logic             icreq_read,
    output logic [PC_W-1:0]  icreq_addr,
    output logic [TAG_W-1:0] icreq_tag,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [TAG_W-1:0] rsp_tag,
    output logic             dec_valid,
    input  logic             dec_ready,
    output logic [PC_W-1:0]  dec_pc,
    output logic [WID_W-1:0] dec_warp,
    output logic [CNT_W-1:0] outstanding,
    output logic [LAT_W-1:0] lat_total
);

    logic [NUM_WARPS-1:0] busy;
    logic [NUM_WARPS-1:0] busy_after_rsp;
    logic                 tag_live;
    logic                 rsp_take;
    logic                 any_free;
    logic [TAG_W-1:0]     free_tag;
    logic                 send;

    // Response stage: look up the tag and decide whether it is consumed.
    always_comb begin
        tag_live  = busy[rsp_tag];
        dec_valid = rsp_valid && tag_live;
        rsp_take  = dec_valid && dec_ready;
        rsp_ready = dec_ready || !tag_live;
    end

    // Busy view after response handling, so a freed tag is free at once.
    always_comb begin
        busy_after_rsp = busy;
        if (rsp_take) begin
            busy_after_rsp[rsp_tag] = 1'b0;
        end
    end

    ift_free_pick #(
        .NUM_SLOTS (NUM_WARPS),
        .TAG_W     (TAG_W)
    ) u_pick (
        .busy     (busy_after_rsp),
        .any_free (any_free),
        .pick     (free_tag)
    );

    // Request stage: send the waiting fetch when a tag is free.
    always_comb begin
        req_ready   = any_free;
        send        = req_valid && any_free;
        icreq_valid = send;
        icreq_read  = 1'b1;
        icreq_addr  = req_pc;
        icreq_tag   = free_tag;
    end

    ift_tag_table #(
        .NUM_SLOTS (NUM_WARPS),
        .TAG_W     (TAG_W),
        .PC_W      (PC_W),
        .WID_W     (WID_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (send),
        .alloc_tag  (free_tag),
        .alloc_pc   (req_pc),
        .alloc_warp (req_warp),
        .free_en    (rsp_take),
        .free_tag   (rsp_tag),
        .rd_tag     (rsp_tag),
        .busy       (busy),
        .rd_pc      (dec_pc),
        .rd_warp    (dec_warp)
    );

    ift_counters #(
        .CNT_W (CNT_W),
        .LAT_W (LAT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc         (send),
        .dec         (rsp_take),
        .outstanding (outstanding),
        .lat_total   (lat_total)
    );

endmodule

// File: rtl/ift_checker.sv
// Module ift_checker
// Cycle-level properties of the fetch tag tracker, attached by bind.
// Assumes: the same parameters as the bound tracker.
module ift_checker #(
    parameter int unsigned NUM_WARPS = 4,
    parameter int unsigned TAG_W     = 2,
    parameter int unsigned CNT_W     = 3,
    parameter int unsigned LAT_W     = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             icreq_valid,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             dec_valid,
    input logic             dec_ready,
    input logic [CNT_W-1:0] outstanding,
    input logic [LAT_W-1:0] lat_total
);

    // R1: the first cycle out of reset starts with nothing in flight.
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (outstanding == '0 && lat_total == '0));

    // R3: with every tag in use and nothing consumed, no request goes out.
    assert_stall_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding == CNT_W'(NUM_WARPS) && !(dec_valid && dec_ready)) |-> !icreq_valid);

    // R5: a live response that decode cannot take is not taken.
    assert_hold_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |-> !rsp_ready);

    // R7: a response with no live tag never blocks and never reaches decode.
    assert_stale_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !dec_valid) |-> rsp_ready);

    // R8: the count moves by sent minus consumed.
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (outstanding == $past(outstanding)
            + CNT_W'($past(icreq_valid)) - CNT_W'($past(dec_valid && dec_ready))));

    // R8: the count never exceeds the number of tags.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CNT_W'(NUM_WARPS));

    // R9: the latency total steps by the previous count.
    assert_lat_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lat_total == $past(lat_total) + LAT_W'($past(outstanding))));

endmodule

bind ifetch_tag_tracker ift_checker #(
    .NUM_WARPS (NUM_WARPS),
    .TAG_W     (TAG_W),
    .CNT_W     (CNT_W),
    .LAT_W     (LAT_W)
) u_ift_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .icreq_valid (icreq_valid),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .dec_valid   (dec_valid),
    .dec_ready   (dec_ready),
    .outstanding (outstanding),
    .lat_total   (lat_total)
);

// File: tb/tb_ifetch_tag_tracker.sv
module tb_ifetch_tag_tracker;

    localparam int unsigned NW    = 4;
    localparam int unsigned PC_W  = 32;
    localparam int unsigned LAT_W = 32;
    localparam int unsigned TAG_W = 2;
    localparam int unsigned CNT_W = 3;
    localparam time         HALF  = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [PC_W-1:0]  req_pc = '0;
    logic [TAG_W-1:0] req_warp = '0;
    logic             icreq_valid;
    logic             icreq_read;
    logic [PC_W-1:0]  icreq_addr;
    logic [TAG_W-1:0] icreq_tag;
    logic             rsp_valid = 1'b0;
    logic             rsp_ready;
    logic [TAG_W-1:0] rsp_tag = '0;
    logic             dec_valid;
    logic             dec_ready = 1'b0;
    logic [PC_W-1:0]  dec_pc;
    logic [TAG_W-1:0] dec_warp;
    logic [CNT_W-1:0] outstanding;
    logic [LAT_W-1:0] lat_total;

    always #HALF clk = ~clk;

    ifetch_tag_tracker #(.NUM_WARPS(NW), .PC_W(PC_W), .LAT_W(LAT_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc), .req_warp(req_warp),
        .icreq_valid(icreq_valid), .icreq_read(icreq_read), .icreq_addr(icreq_addr),
        .icreq_tag(icreq_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_pc(dec_pc), .dec_warp(dec_warp),
        .outstanding(outstanding), .lat_total(lat_total)
    );

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          finished = 1'b0;

    // Reference model state, kept from the requirements.
    bit          m_busy [NW];
    logic [31:0] m_pc   [NW];
    logic [1:0]  m_wid  [NW];
    int unsigned m_cnt;
    logic [31:0] m_lat;
    int          last_tag;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NW; i++) begin
            m_busy[i] = 1'b0;
            m_pc[i]   = '0;
            m_wid[i]  = '0;
        end
        m_cnt = 0;
        m_lat = '0;
    endtask

    // One cycle: drive inputs, compare at the falling edge, update the model after the rising edge.
    task automatic cycle(input bit rv, input logic [31:0] pc, input logic [1:0] wid,
                         input bit sv, input logic [1:0] stag, input bit dr);
        bit          live;
        bit          take;
        bit          freeb [NW];
        bit          has;
        int          pick;
        req_valid = rv; req_pc = pc; req_warp = wid;
        rsp_valid = sv; rsp_tag = stag; dec_ready = dr;
        @(negedge clk);
        live = m_busy[stag];
        take = sv && live && dr;
        has  = 1'b0;
        pick = 0;
        for (int i = NW - 1; i >= 0; i--) begin
            freeb[i] = !m_busy[i] || (take && stag == 2'(i));
            if (freeb[i]) begin
                has  = 1'b1;
                pick = i;
            end
        end
        chk("R8", "outstanding", 32'(outstanding), m_cnt);
        chk("R9", "lat_total", lat_total, m_lat);
        chk(has ? "R2" : "R3", "req_ready", 32'(req_ready), 32'(has));
        chk(has ? "R2" : "R3", "icreq_valid", 32'(icreq_valid), 32'(rv && has));
        if (rv && has) begin
            chk("R2", "icreq_tag", 32'(icreq_tag), pick);
            chk("R2", "icreq_addr", icreq_addr, pc);
            chk("R2", "icreq_read", 32'(icreq_read), 1);
        end
        if (sv) begin
            chk(live ? "R4" : "R7", "dec_valid", 32'(dec_valid), 32'(live));
            chk(live ? (dr ? "R4" : "R5") : "R7", "rsp_ready", 32'(rsp_ready),
                32'(dr || !live));
            if (live) begin
                chk("R4", "dec_pc", dec_pc, m_pc[stag]);
                chk("R4", "dec_warp", 32'(dec_warp), 32'(m_wid[stag]));
            end
        end else begin
            chk("R4", "dec_valid idle", 32'(dec_valid), 0);
        end
        last_tag = (rv && has) ? pick : -1;
        @(posedge clk);
        #1;
        m_lat = m_lat + m_cnt;
        if (take) begin
            m_busy[stag] = 1'b0;
            m_cnt--;
        end
        if (rv && has) begin
            m_busy[pick] = 1'b1;
            m_pc[pick]   = pc;
            m_wid[pick]  = wid;
            m_cnt++;
        end
    endtask

    initial begin
        #(200000 * 2 * HALF);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: empty state right after reset.
        chk("R1", "outstanding", 32'(outstanding), 0);
        chk("R1", "lat_total", lat_total, 0);
        chk("R1", "req_ready", 32'(req_ready), 1);
        @(posedge clk); #1;

        // R1 and R2: fill all tags in order 0..3.
        for (int k = 0; k < NW; k++) begin
            cycle(1'b1, 32'h1000 + 32'(k * 4), 2'(3 - k), 1'b0, 2'd0, 1'b1);
            chk(k == 0 ? "R1" : "R2", "tag order", last_tag, k);
        end
        // R3: fifth request stalls with all tags busy.
        cycle(1'b1, 32'h2000, 2'd1, 1'b0, 2'd0, 1'b1);
        chk("R3", "no tag given", last_tag, -1);
        // R5: response for tag 2 held while decode is not ready.
        cycle(1'b1, 32'h2000, 2'd1, 1'b1, 2'd2, 1'b0);
        chk("R5", "still stalled", last_tag, -1);
        // R6: tag 2 freed and reused in the same cycle.
        cycle(1'b1, 32'h2000, 2'd1, 1'b1, 2'd2, 1'b1);
        chk("R6", "reused tag", last_tag, 2);
        // R7: consume tag 0, then a stale response on tag 0.
        cycle(1'b0, 32'h0, 2'd0, 1'b1, 2'd0, 1'b1);
        cycle(1'b0, 32'h0, 2'd0, 1'b1, 2'd0, 1'b1);
        chk("R7", "count after stale", 32'(outstanding), 3);
        // R4: return the reused tag 2 and check its new context.
        cycle(1'b0, 32'h0, 2'd0, 1'b1, 2'd2, 1'b1);

        // Near-exhaustive sweep over all tags and handshake combinations.
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cycle(lf[0] | lf[1], {lf, lf ^ 16'h5A5A}, lf[8:7],
                  lf[2] | lf[9], lf[4:3], lf[5] | lf[6]);
        end

        // R8 and R9 final totals after draining everything.
        for (int t = 0; t < NW; t++) cycle(1'b0, 32'h0, 2'd0, 1'b1, 2'(t), 1'b1);
        @(negedge clk);
        chk("R8", "drained count", 32'(outstanding), 0);
        chk("R9", "final lat_total", lat_total, m_lat);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule